// File: doc/BRIEF.md
# Seven-Input Trigger Priority Latch

This block takes seven active-low, level-sensitive trigger lines and turns them into one request for a list sequencer. Every line passes through a two-stage synchronizer and then a low-time qualifier. A line that stays low long enough becomes a pending request. Pending requests are stored until they are serviced. When the sequencer is idle, the highest-numbered pending request is handed over as a 3-bit code.

The code is held steady while its list runs. When the sequencer signals completion, or when a stop condition ends the list, the serviced request is cleared. If the same line is still held low at that moment, it qualifies again and its list runs again.

A global enable gates all inputs. While it is low, nothing is accepted and nothing is stored. A triggered flag records that an enabled trigger went low, and three indicator outputs show the code of the list that is running.

The controller has two states. `ST_IDLE` waits for work. It takes the transition *launch* to `ST_RUN` when a request is pending and `seq_idle` is high. `ST_RUN` holds the code. It takes the transition *complete* back to `ST_IDLE` on `list_done` or `stop_evt`.

Top module: `trig_prio_latch`

## Requirements
- R1: After reset, `code_valid`, `triggered`, `ind` and `code` are all 0, and nothing is pending.
- R2: A trigger line is accepted only when it is held low for at least QUAL_CYCLES consecutive clock cycles (default 15, which is 300 ns at 50 MHz). A shorter low pulse is ignored.
- R3: An accepted request stays pending after its line goes high again, until it is serviced.
- R4: Line `trig_n[i]` is trigger i+1 and has code i+1. When several requests are pending, the one with the largest code is presented first, so trigger 7 wins.
- R5: A code is presented (`code_valid`=1) only by a launch from `ST_IDLE` while `seq_idle` is 1. While `seq_idle` is 0, pending requests wait.
- R6: While in `ST_RUN`, `code` and `code_valid` do not change until `list_done` or `stop_evt`, even if new requests arrive.
- R7: `list_done` in `ST_RUN` clears the serviced request and returns to `ST_IDLE`. The next-highest pending request is then launched.
- R8: A trigger that is still held low when its list completes is presented again.
- R9: While `trig_en` is 0, inputs are ignored and all pending requests are dropped.
- R10: `triggered` is set when an enabled trigger line is accepted after going low. It is cleared by `stop_evt` or by reset, and the clear wins if both happen in the same cycle.
- R11: `ind` equals `code` while in `ST_RUN` and is 0 in `ST_IDLE`.
- R12: `stop_evt` in `ST_RUN` ends the list in the same way as completion: the serviced request is cleared and the state returns to `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low module reset |
| trig_n | input | 7 | Trigger lines, active low; bit i is trigger i+1 |
| trig_en | input | 1 | Global trigger enable |
| seq_idle | input | 1 | Sequencer is in its reset state and can accept a code |
| list_done | input | 1 | One-cycle pulse: the running list completed |
| stop_evt | input | 1 | One-cycle pulse: a stop condition occurred |
| code | output | 3 | Code of the trigger being serviced |
| code_valid | output | 1 | A list for `code` is running |
| triggered | output | 1 | An enabled trigger has fired since the last stop |
| ind | output | 3 | Code indicators, dark when no list runs |

## Verification
The bench drives low pulses one cycle shorter than the qualifier and exactly its length. A qualifier with an off-by-one error would either drop valid triggers or accept glitches. It applies several pending masks and drains them in order; a reversed or low-first encoder would hand over the wrong list first. It also covers three timing corner cases:
- A higher trigger that arrives mid-list must not change the code. A design that re-evaluates the code while running would switch lists partway through.
- A trigger still held at completion must fire again. A design that used edges instead of levels would lose it.
- A disable while a request is pending, and a stop event, must leave nothing behind. A design that kept either request would start a stale list later.

// File: rtl/trig_pkg.sv
package trig_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tl_state_e;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_n,
    output logic [W-1:0] lvl
);
    logic [W-1:0] stg1_n, stg2_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg1_n <= '1;
            stg2_n <= '1;
        end else begin
            stg1_n <= raw_n;
            stg2_n <= stg1_n;
        end
    end

    assign lvl = ~stg2_n;
endmodule

// File: rtl/trig_qual.sv
module trig_qual #(
    parameter int W           = 7,
    parameter int QUAL_CYCLES = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] qual,
    output logic [W-1:0] rise
);
    localparam int CNT_W = $clog2(QUAL_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(QUAL_CYCLES);

    logic [W-1:0] qual_d;

    for (genvar i = 0; i < W; i++) begin : g_ch
        logic [CNT_W-1:0] cnt;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cnt <= '0;
            else if (!en || !lvl[i])
                cnt <= '0;
            else if (cnt != LIM)
                cnt <= cnt + 1'b1;
        end

        assign qual[i] = (cnt == LIM);

        // R2: a request only appears after the synchronized line was active
        p_qual_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(qual[i]) |-> $past(lvl[i]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) qual_d <= '0;
        else        qual_d <= qual;
    end

    assign rise = qual & ~qual_d;
endmodule

// File: rtl/trig_pend.sv
module trig_pend #(
    parameter int W      = 7,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [W-1:0]      qual,
    input  logic              clr,
    input  logic [CODE_W-1:0] clr_code,
    output logic [W-1:0]      pend
);
    logic [W-1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        for (int i = 0; i < W; i++)
            if (clr && clr_code == CODE_W'(i + 1)) clr_mask[i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pend <= '0;
        else if (!en) pend <= '0;
        else          pend <= (pend | qual) & ~clr_mask;
    end

    // R9: a disable empties the request store
    p_drop_on_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (pend == '0));
endmodule

// File: rtl/trig_prio_latch.sv
module trig_prio_latch
    import trig_pkg::*;
#(
    parameter int NUM_TRIG    = 7,
    parameter int QUAL_CYCLES = 15,
    localparam int CODE_W     = $clog2(NUM_TRIG + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TRIG-1:0] trig_n,
    input  logic                trig_en,
    input  logic                seq_idle,
    input  logic                list_done,
    input  logic                stop_evt,
    output logic [CODE_W-1:0]   code,
    output logic                code_valid,
    output logic                triggered,
    output logic [CODE_W-1:0]   ind
);
    logic [NUM_TRIG-1:0] lvl, qual, rise, pend;
    logic [CODE_W-1:0]   hi_code, code_q;
    logic                launch, finish;
    tl_state_e           state_q, state_d;

    trig_sync #(.W(NUM_TRIG)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_n(trig_n), .lvl(lvl)
    );

    trig_qual #(.W(NUM_TRIG), .QUAL_CYCLES(QUAL_CYCLES)) u_qual (
        .clk(clk), .rst_n(rst_n), .en(trig_en), .lvl(lvl), .qual(qual), .rise(rise)
    );

    trig_pend #(.W(NUM_TRIG), .CODE_W(CODE_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .en(trig_en), .qual(qual),
        .clr(finish), .clr_code(code_q), .pend(pend)
    );

    // highest-numbered pending request wins
    always_comb begin
        hi_code = '0;
        for (int i = 0; i < NUM_TRIG; i++)
            if (pend[i]) hi_code = CODE_W'(i + 1);
    end

    assign launch = (state_q == ST_IDLE) && seq_idle && (pend != '0);
    assign finish = (state_q == ST_RUN) && (list_done || stop_evt);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch) state_d = ST_RUN;
            ST_RUN:  if (finish) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            code_q    <= '0;
            triggered <= 1'b0;
        end else begin
            state_q <= state_d;
            if (launch) code_q <= hi_code;
            if (stop_evt)        triggered <= 1'b0;
            else if (rise != '0) triggered <= 1'b1;
        end
    end

    always_comb begin
        code       = code_q;
        code_valid = 1'b0;
        ind        = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN: begin
                code_valid = 1'b1;
                ind        = code_q;
            end
            default: ;
        endcase
    end

    // R6: code frozen while a list runs
    p_code_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && !list_done && !stop_evt) |=> (code_valid && $stable(code)));

    // R5: a launch only happens while the sequencer was idle
    p_launch_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(code_valid) |-> $past(seq_idle));

    // R4: no pending request above the launched code
    p_pick_highest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(code_valid) |-> (($past(pend) >> code) == '0));

    // R10: stop clears the triggered flag
    p_stop_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !triggered);

    // R11: indicators dark when no list runs
    p_ind_dark_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !code_valid |-> (ind == '0));

    // R12: stop ends the running list
    p_stop_ends_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && stop_evt) |=> !code_valid);
endmodule

// File: tb/tb_trig_prio_latch.sv
module tb_trig_prio_latch;
    localparam int Q = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] trig_n = '1;
    logic       trig_en = 1'b0;
    logic       seq_idle = 1'b1;
    logic       list_done = 1'b0;
    logic       stop_evt = 1'b0;
    logic [2:0] code, ind;
    logic       code_valid, triggered;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    trig_prio_latch #(.NUM_TRIG(7), .QUAL_CYCLES(Q)) dut (
        .clk(clk), .rst_n(rst_n), .trig_n(trig_n), .trig_en(trig_en),
        .seq_idle(seq_idle), .list_done(list_done), .stop_evt(stop_evt),
        .code(code), .code_valid(code_valid), .triggered(triggered), .ind(ind)
    );

    // {mask of triggers (bit i = trigger i+1), first code, second code}
    localparam logic [12:0] VEC [0:4] = '{
        {7'h7F, 3'd7, 3'd6},
        {7'h01, 3'd1, 3'd0},
        {7'h12, 3'd5, 3'd2},
        {7'h44, 3'd7, 3'd3},
        {7'h09, 3'd4, 3'd1}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [6:0] mask, input int len);
        trig_n = ~mask;
        step(len);
        trig_n = '1;
    endtask

    task automatic finish_list();
        list_done = 1'b1;
        step(1);
        list_done = 1'b0;
        step(4);
    endtask

    task automatic drain();
        for (int k = 0; k < 8; k++)
            if (code_valid) finish_list();
    endtask

    initial begin
        int cyc = 0;
        while (!done_flag) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_bad++;
                $display("FAIL watchdog expired actual=running expected=finished");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        // R1 reset state
        chk("R1 code_valid", code_valid, 0);
        chk("R1 triggered", triggered, 0);
        chk("R1 ind", ind, 0);
        chk("R1 code", code, 0);

        // R9: disabled inputs ignored, nothing stored
        pulse(7'h04, Q + 2);
        step(6);
        chk("R9 disabled valid", code_valid, 0);
        chk("R10 disabled triggered", triggered, 0);
        trig_en = 1'b1;
        step(6);
        chk("R9 nothing stored", code_valid, 0);

        // R2: one cycle short is rejected, exact length accepted
        pulse(7'h08, Q - 1);
        step(8);
        chk("R2 short pulse", code_valid, 0);
        pulse(7'h08, Q);
        step(8);
        chk("R2 exact pulse valid", code_valid, 1);
        chk("R2 exact pulse code", code, 4);
        chk("R10 triggered set", triggered, 1);
        finish_list();
        chk("R7 done idle", code_valid, 0);
        chk("R11 ind dark", ind, 0);

        // R3 R4 R7 table
        for (int v = 0; v < 5; v++) begin
            logic [6:0] m;
            logic [2:0] c1, c2;
            {m, c1, c2} = VEC[v];
            pulse(m, Q + 2);
            step(6);
            chk("R3 latched valid", code_valid, 1);
            chk("R4 first code", code, c1);
            chk("R11 ind follows", ind, c1);
            finish_list();
            if (c2 != 0) begin
                chk("R7 next valid", code_valid, 1);
                chk("R7 next code", code, c2);
            end
            drain();
            chk("R7 drained", code_valid, 0);
        end

        // R5: wait while sequencer busy
        seq_idle = 1'b0;
        pulse(7'h08, Q + 2);
        step(6);
        chk("R5 held while busy", code_valid, 0);
        seq_idle = 1'b1;
        step(2);
        chk("R5 launched", code_valid, 1);
        chk("R5 code", code, 4);
        finish_list();

        // R9: disable drops pending request
        seq_idle = 1'b0;
        pulse(7'h10, Q + 2);
        step(6);
        trig_en = 1'b0;
        step(2);
        trig_en = 1'b1;
        seq_idle = 1'b1;
        step(4);
        chk("R9 pending dropped", code_valid, 0);

        // R6: higher trigger mid-list does not change code
        trig_n = ~7'h02;
        step(Q + 6);
        chk("R6 running code", code, 2);
        pulse(7'h40, Q + 2);
        trig_n = ~7'h02;
        step(6);
        chk("R6 code frozen", code, 2);
        chk("R6 ind frozen", ind, 2);
        trig_n = '1;
        step(4);
        finish_list();
        chk("R4 late trigger 7", code, 7);
        drain();

        // R8: held trigger re-fires
        trig_n = ~7'h04;
        step(Q + 6);
        chk("R8 first run", code, 3);
        finish_list();
        chk("R8 re-fire valid", code_valid, 1);
        chk("R8 re-fire code", code, 3);
        trig_n = '1;
        step(4);
        finish_list();
        chk("R8 released", code_valid, 0);

        // R10 R12: stop ends list and clears flag
        pulse(7'h20, Q + 2);
        step(6);
        chk("R12 running", code, 6);
        chk("R10 flag before stop", triggered, 1);
        stop_evt = 1'b1;
        step(1);
        stop_evt = 1'b0;
        step(4);
        chk("R12 stop ends list", code_valid, 0);
        chk("R12 ind dark", ind, 0);
        chk("R10 flag cleared", triggered, 0);

        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule